// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link: a clock pin, a data-out pin and a data-in pin. A single 8-bit register does both jobs. Writing a byte loads it as the outgoing data and starts the transfer. As each bit leaves, the bit arriving on the input pin is shifted in behind it. After eight bits the same register holds the received byte, and software reads it back through the read port.

The transfer clock comes from one of two places. In internal mode an on-chip divider makes the clock from a prescaled system clock, drives the clock pin, and stops by itself after eight pulses. In external mode a partner device supplies the clock on the clock pin. That clock is synchronised into the system clock domain, and every edge shifts the register, for as many edges as arrive. A polarity input sets which edge moves data out, which edge captures data, and the idle level of the clock. A bit-order input picks least-significant-bit first or most-significant-bit first. A one-cycle pulse marks the end of each byte.

Top module: `sync_serial_unit`

## Requirements
- R1: One 8-bit register serves both directions. After the eighth capture edge, `rd_data` equals the byte the partner presented on `sin`, interpreted in the same bit order as the transmit data.
- R2: In internal mode the clock half-period is H = (div_val+1)*P system cycles. P is 1 for `src_sel`=0, 8 for `src_sel`=1, and 32 for `src_sel`=2 or 3. The first clock edge comes H cycles after the write, and each later edge comes H cycles after the one before.
- R3: A write (`wr_en`=1) starts a transfer. `busy` is 1 from the cycle after the write until the eighth capture edge, and it falls in that same cycle.
- R4: `done_irq` is a single-cycle pulse, raised exactly once per byte, at the eighth capture edge. That edge is rising when `pol`=0 and falling when `pol`=1.
- R5: In internal mode the clock pin is driven (`sclk_oe`=1) and stops after sixteen edges at its idle level: 1 when `pol`=0, 0 when `pol`=1. In external mode `sclk_oe`=0.
- R6: In internal mode `sout_oe` is 0 from the write until the first launch edge. After the last edge, `sout` keeps the final bit for H cycles and then `sout_oe` drops to 0. A write during that hold interval makes `sout_oe` 0 in the very next cycle.
- R7: With `lsb_first`=1, bit 0 leaves first and bit 7 leaves last. With `lsb_first`=0, the order is reversed.
- R8: In external mode `sout_oe` is always 1, and `sout` equals `idle_level` whenever no transfer is in progress.
- R9: The launch edge changes `sout`: falling when `pol`=0, rising when `pol`=1. The opposite edge captures `sin`. In external mode a launch on `sclk_in` shows up on `sout` within four system cycles.
- R10: In external mode, capture edges that arrive after a byte is complete keep shifting the register in the selected bit order. They raise no `done_irq` and leave `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe: load `wr_data` and start a transfer |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Current contents of the shift register |
| busy | output | 1 | Transfer in progress |
| int_mode | input | 1 | 1 = internal divided clock, 0 = external clock pin |
| src_sel | input | 2 | Prescaler choice: 0 = /1, 1 = /8, 2 or 3 = /32 |
| div_val | input | 8 | Divider setting n |
| pol | input | 1 | Clock polarity: 0 = idle high, launch on fall, capture on rise |
| lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| idle_level | input | 1 | `sout` level while idle in external mode |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Output enable for `sout` (0 = high impedance) |
| sclk_in | input | 1 | Clock pin input value |
| sclk_out | output | 1 | Clock pin output value |
| sclk_oe | output | 1 | Clock pin output enable |
| done_irq | output | 1 | End-of-byte pulse |

## Verification
The embedded properties hold on every cycle:
- a write always leaves the unit busy;
- `busy` never drops without a completion pulse, and no pulse appears unless a transfer was active;
- an internal-mode write releases the data pin;
- the internal clock is back at its idle level when the pulse fires.

Other behaviour only shows up in the bench's scenarios. These are the divider spacing of every edge for each prescaler choice, the exact bit sequence on `sout` in both orders, the received byte, the length of the post-transfer hold, and the extra shifting caused by surplus external edges.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

  localparam int unsigned SSU_W = 8;

  // Half-period of the internal transfer clock in system cycles.
  function automatic int unsigned half_cycles(input logic [1:0] sel,
                                              input int unsigned n,
                                              input int unsigned pre_a,
                                              input int unsigned pre_b,
                                              input int unsigned pre_c);
    int unsigned p;
    case (sel)
      2'd0:    p = pre_a;
      2'd1:    p = pre_b;
      default: p = pre_c;
    endcase
    return (n + 1) * p;
  endfunction

  // Bit that sits at the transmitting end of the register.
  function automatic logic out_end_bit(input logic [SSU_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[SSU_W-1];
  endfunction

  // One shift step: move toward the transmitting end, insert at the far end.
  function automatic logic [SSU_W-1:0] shift_in(input logic [SSU_W-1:0] v,
                                                input logic b,
                                                input logic lsb);
    return lsb ? {b, v[SSU_W-1:1]} : {v[SSU_W-2:0], b};
  endfunction

endpackage

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_A = 1,
  parameter int unsigned PRE_B = 8,
  parameter int unsigned PRE_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + $clog2(PRE_C) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb
    limit = CNT_W'(ssu_pkg::half_cycles(src_sel, 32'(div_val), PRE_A, PRE_B, PRE_C) - 1);

  assign tick = (cnt_q >= limit);

  // restart on a write so the first half-period is a whole one (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ssu_edge_sync.sv
module ssu_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/ssu_shift_core.sv
module ssu_shift_core
  import ssu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SSU_W-1:0] wr_data,
  input  logic             int_mode,
  input  logic             pol,
  input  logic             lsb_first,
  input  logic             tick,
  input  logic             ext_rise,
  input  logic             ext_fall,
  input  logic             sin,
  output logic [SSU_W-1:0] shreg,
  output logic             busy,
  output logic             done_irq,
  output logic             obit,
  output logic             oe_int,
  output logic             sclk_lvl
);
  localparam int unsigned CNT_W = $clog2(SSU_W);

  logic [SSU_W-1:0] sh_q;
  logic [CNT_W-1:0] scnt_q;
  logic busy_q, hold_q, oe_q, obit_q, sclk_q, irq_q;

  // named events, visible to the assertions below
  logic idle_lvl;
  logic int_launch, int_sample, ext_launch, ext_sample;
  logic launch_ev, sample_ev, last_sample;

  assign idle_lvl    = ~pol;
  assign int_launch  = int_mode && busy_q && tick && (sclk_q == idle_lvl);
  assign int_sample  = int_mode && busy_q && tick && (sclk_q != idle_lvl);
  assign ext_launch  = !int_mode && (pol ? ext_rise : ext_fall);
  assign ext_sample  = !int_mode && (pol ? ext_fall : ext_rise);
  assign launch_ev   = int_launch | ext_launch;
  assign sample_ev   = int_sample | ext_sample;
  assign last_sample = busy_q && sample_ev && (scnt_q == CNT_W'(SSU_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      scnt_q <= '0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      oe_q   <= 1'b0;
      obit_q <= 1'b0;
      sclk_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= last_sample && !wr_en;
      if (wr_en) begin
        sh_q   <= wr_data;
        scnt_q <= '0;
        busy_q <= 1'b1;
        hold_q <= 1'b0;
        oe_q   <= 1'b0;
        obit_q <= out_end_bit(wr_data, lsb_first);
        sclk_q <= idle_lvl;
      end else begin
        if (sample_ev) begin
          sh_q <= shift_in(sh_q, sin, lsb_first);
          if (busy_q) scnt_q <= scnt_q + 1'b1;
        end
        if (launch_ev) begin
          obit_q <= out_end_bit(sh_q, lsb_first);
          if (int_launch) oe_q <= 1'b1;
        end
        if (int_launch || int_sample) sclk_q <= ~sclk_q;
        if (last_sample) begin
          busy_q <= 1'b0;
          hold_q <= int_mode;
        end else if (hold_q && tick) begin
          hold_q <= 1'b0;
          oe_q   <= 1'b0;
        end
      end
    end
  end

  assign shreg    = sh_q;
  assign busy     = busy_q;
  assign done_irq = irq_q;
  assign obit     = obit_q;
  assign oe_int   = oe_q;
  assign sclk_lvl = sclk_q;

  // R3: a write always leaves the unit busy
  p_busy_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy_q);

  // R4: busy only ends together with the completion pulse
  p_irq_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq_q);

  // R4: no completion pulse without an active transfer
  p_irq_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(busy_q));

  // R6: an internal-mode write releases the data pin
  p_wr_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int_mode) |=> !oe_q);

  // R5: the internal clock sits at its idle level when the byte completes
  p_idle_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && int_mode) |-> (sclk_q == ~pol));

endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PRE_A       = 1,
  parameter int unsigned PRE_B       = 8,
  parameter int unsigned PRE_C       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             busy,
  input  logic             int_mode,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             pol,
  input  logic             lsb_first,
  input  logic             idle_level,
  input  logic             sin,
  output logic             sout,
  output logic             sout_oe,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             done_irq
);
  logic tick, ext_rise, ext_fall;
  logic obit, oe_int, sclk_lvl;

  ssu_clkgen #(
    .DIV_W (DIV_W),
    .PRE_A (PRE_A),
    .PRE_B (PRE_B),
    .PRE_C (PRE_C)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_en),
    .src_sel (src_sel),
    .div_val (div_val),
    .tick    (tick)
  );

  ssu_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sclk_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  ssu_shift_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .int_mode  (int_mode),
    .pol       (pol),
    .lsb_first (lsb_first),
    .tick      (tick),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall),
    .sin       (sin),
    .shreg     (rd_data),
    .busy      (busy),
    .done_irq  (done_irq),
    .obit      (obit),
    .oe_int    (oe_int),
    .sclk_lvl  (sclk_lvl)
  );

  // pin drive: the internal mode uses the hold/enable register,
  // the external mode drives continuously with an idle level
  assign sout     = (int_mode || busy) ? obit : idle_level;
  assign sout_oe  = int_mode ? oe_int : 1'b1;
  assign sclk_out = busy ? sclk_lvl : ~pol;
  assign sclk_oe  = int_mode;

endmodule

// File: tb/sync_serial_unit_tb_top.sv
module sync_serial_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy;
  logic       int_mode = 1'b1;
  logic [1:0] src_sel = 2'd0;
  logic [7:0] div_val = 8'd0;
  logic       pol = 1'b0;
  logic       lsb_first = 1'b1;
  logic       idle_level = 1'b0;
  logic       sin = 1'b0;
  logic       sout, sout_oe;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe;
  logic       done_irq;

  int vec_cnt = 0;
  int err_cnt = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  sync_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .int_mode(int_mode), .src_sel(src_sel), .div_val(div_val), .pol(pol),
    .lsb_first(lsb_first), .idle_level(idle_level), .sin(sin), .sout(sout),
    .sout_oe(sout_oe), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .done_irq(done_irq)
  );

  always @(negedge clk) if (done_irq === 1'b1) irq_cnt++;

  function automatic int exp_half(input logic [1:0] sel, input logic [7:0] n);
    int p;
    p = (sel == 2'd0) ? 1 : ((sel == 2'd1) ? 8 : 32);
    return (int'(n) + 1) * p;
  endfunction

  function automatic logic tx_bit(input logic [7:0] d, input int k, input logic lsb);
    return lsb ? d[k] : d[7-k];
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_int(input logic [7:0] d, input logic [7:0] s, input logic [1:0] sel,
                         input logic [7:0] n, input logic p, input logic lsb, input bit early);
    int h, cyc, edges, k, hold_cnt, irq0;
    logic prev;
    h = exp_half(sel, n);
    @(negedge clk);
    int_mode = 1'b1; src_sel = sel; div_val = n; pol = p; lsb_first = lsb; sin = 1'b0;
    @(negedge clk);
    irq0 = irq_cnt;
    do_write(d);
    check(busy === 1'b1, "R3 busy after write", int'(busy), 1);
    check(sout_oe === 1'b0, "R6 data pin released before first launch", int'(sout_oe), 0);
    check(sclk_oe === 1'b1, "R5 clock pin driven in internal mode", int'(sclk_oe), 1);
    prev = sclk_out;
    cyc = 0;
    edges = 0;
    while (edges < 16) begin
      @(negedge clk);
      cyc++;
      if (sclk_out !== prev) begin
        edges++;
        prev = sclk_out;
        check(cyc == h, "R2 edge spacing", cyc, h);
        cyc = 0;
        if (edges % 2 == 1) begin
          k = (edges - 1) / 2;
          check(sclk_out === p, "R9 launch edge direction", int'(sclk_out), int'(p));
          check(sout_oe === 1'b1 && sout === tx_bit(d, k, lsb), "R7 transmitted bit",
                int'(sout), int'(tx_bit(d, k, lsb)));
          sin = tx_bit(s, k, lsb);
        end else begin
          check(done_irq === (edges == 16), "R4 pulse only at last capture edge",
                int'(done_irq), int'(edges == 16));
        end
      end
    end
    check(busy === 1'b0, "R3 busy clears at last capture edge", int'(busy), 0);
    check(sclk_out === !p, "R5 clock parks at idle level", int'(sclk_out), int'(!p));
    check(sout_oe === 1'b1 && sout === tx_bit(d, 7, lsb), "R6 last bit held",
          int'(sout), int'(tx_bit(d, 7, lsb)));
    if (!early) begin
      hold_cnt = 0;
      while (sout_oe === 1'b1) begin
        @(negedge clk);
        hold_cnt++;
      end
      check(hold_cnt == h, "R6 hold length", hold_cnt, h);
      check(rd_data === s, "R1 received byte", int'(rd_data), int'(s));
      check(irq_cnt == irq0 + 1, "R4 one pulse per byte", irq_cnt, irq0 + 1);
    end else begin
      @(negedge clk);
      check(irq_cnt == irq0 + 1, "R4 one pulse per byte", irq_cnt, irq0 + 1);
      check(rd_data === s, "R1 received byte", int'(rd_data), int'(s));
      do_write(~d);
      check(sout_oe === 1'b0, "R6 write during hold releases pin", int'(sout_oe), 0);
      check(busy === 1'b1, "R3 new transfer from hold", int'(busy), 1);
      while (busy === 1'b1) @(negedge clk);
      while (sout_oe === 1'b1) @(negedge clk);
    end
  endtask

  task automatic run_ext(input logic [7:0] d, input logic [7:0] s, input logic p,
                         input logic lsb, input logic idle, input bit extra);
    int irq0;
    logic [7:0] exp_v;
    logic b;
    @(negedge clk);
    pol = p; lsb_first = lsb; idle_level = idle; sclk_in = !p; int_mode = 1'b0;
    repeat (6) @(negedge clk);
    check(sout_oe === 1'b1 && sout === idle, "R8 idle level driven", int'(sout), int'(idle));
    check(sclk_oe === 1'b0, "R5 clock pin not driven in external mode", int'(sclk_oe), 0);
    irq0 = irq_cnt;
    do_write(d);
    check(busy === 1'b1 && sout === tx_bit(d, 0, lsb), "R7 first bit on write",
          int'(sout), int'(tx_bit(d, 0, lsb)));
    for (int k = 0; k < 8; k++) begin
      sclk_in = p;
      repeat (4) @(negedge clk);
      check(sout === tx_bit(d, k, lsb), "R9 bit after external launch",
            int'(sout), int'(tx_bit(d, k, lsb)));
      sin = tx_bit(s, k, lsb);
      repeat (4) @(negedge clk);
      sclk_in = !p;
      repeat (8) @(negedge clk);
      if (k < 7) check(busy === 1'b1, "R3 busy during byte", int'(busy), 1);
    end
    check(busy === 1'b0, "R3 busy clears after eighth edge", int'(busy), 0);
    check(rd_data === s, "R1 received byte", int'(rd_data), int'(s));
    check(irq_cnt == irq0 + 1, "R4 one pulse per byte", irq_cnt, irq0 + 1);
    check(sout === idle, "R8 idle level after byte", int'(sout), int'(idle));
    if (extra) begin
      exp_v = s;
      for (int j = 0; j < 2; j++) begin
        b = 1'($urandom);
        sclk_in = p;
        repeat (8) @(negedge clk);
        sin = b;
        sclk_in = !p;
        repeat (8) @(negedge clk);
        exp_v = lsb ? {b, exp_v[7:1]} : {exp_v[6:0], b};
      end
      check(rd_data === exp_v, "R10 surplus edges keep shifting", int'(rd_data), int'(exp_v));
      check(irq_cnt == irq0 + 1, "R10 no pulse on surplus edges", irq_cnt, irq0 + 1);
      check(busy === 1'b0, "R10 busy stays low", int'(busy), 0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done_irq === 1'b0, "R3 reset idle", int'(busy), 0);
    check(sout_oe === 1'b0, "R6 reset pin released", int'(sout_oe), 0);
    check(sclk_out === 1'b1 && sclk_oe === 1'b1, "R5 reset clock idle", int'(sclk_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 8'h00, "R1 reset register", int'(rd_data), 0);

    // directed internal-clock corners
    run_int(8'hA5, 8'h3C, 2'd0, 8'd0,   1'b0, 1'b1, 1'b0);
    run_int(8'h81, 8'hE7, 2'd1, 8'd2,   1'b1, 1'b0, 1'b0);
    run_int(8'h5A, 8'h96, 2'd0, 8'd255, 1'b0, 1'b0, 1'b0);
    run_int(8'h0F, 8'hF0, 2'd3, 8'd1,   1'b1, 1'b1, 1'b0);
    run_int(8'hC3, 8'h18, 2'd0, 8'd3,   1'b0, 1'b1, 1'b1);
    // constrained random internal-clock transfers
    for (int i = 0; i < 6; i++) begin
      run_int(8'($urandom), 8'($urandom), 2'($urandom), 8'($urandom % 8),
              1'($urandom), 1'($urandom), 1'b0);
    end
    // external-clock transfers
    run_ext(8'h96, 8'h4B, 1'b0, 1'b1, 1'b1, 1'b0);
    run_ext(8'h1E, 8'hD2, 1'b1, 1'b0, 1'b0, 1'b1);
    run_ext(8'h77, 8'h88, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      run_ext(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog R3: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule